// File: doc/BRIEF.md
# Programmable AND-OR Logic Array Core

This block is a combinational sum-of-products array whose function is set by a link map. A first plane of AND gates forms product terms from 22 logic variables. Each variable is offered in true and in complement form, and the variables are 12 dedicated inputs plus the values seen on 10 bidirectional pins. Of the 42 AND terms, 32 are logic terms shared freely by 10 OR gates, so one OR can gather every logic term. The other 10 AND terms each switch on the output driver of one bidirectional pin. Every OR result passes through an inversion stage that can be programmed before it reaches its pin.

The map is loaded through a serial port. While the load enable is high, one bit is shifted in per clock, and the outputs keep following the old map. The whole new map takes over on the clock after the load enable drops. Reset brings back the unprogrammed map, in which every link is intact: all terms are then inhibited, every pin is undriven and every output reads 0.

The bidirectional pins are modelled as three vectors: a pin value in, a drive value out and a drive enable. The environment returns the driven value on the pin input of any pin whose driver is on.

Top module: `pla_array_core`

## Requirements
- R1: In the map, the true link of variable v in term t sits at bit 330 + 44*t + 2*v, and the complement link sits one bit higher. Variables 0..11 are `in_ded[0..11]` and variables 12..21 are `pin_in[0..9]`. Terms 0..31 are logic terms and terms 32..41 are drive terms. When only the true link is intact, the term needs the variable to be 1. When only the complement link is intact, the term needs it to be 0. When both links are removed (0), the variable does not affect the term.
- R2: A term in which both links of any one variable are intact evaluates to 0 for every input.
- R3: OR gate k includes logic term p exactly when map bit 10 + 32*k + p is 1. Removed links add 0, and a single OR may include all 32 terms.
- R4: Map bit k (0..9) is the polarity of output k: 1 passes the OR result to `pin_out[k]` unchanged, and 0 inverts it.
- R5: `pin_oe[n]` equals drive term 32+n.
- R6: The value on `pin_in` enters the AND plane, including the value fed back from a pin that is being driven.
- R7: With the unprogrammed map (every bit 1), `pin_out` and `pin_oe` are all 0 for every input.
- R8: On each clock edge with `cfg_load` high, `cfg_din` is shifted into the staged map at bit 0 and the earlier bits move up by one. The 2178-bit map is therefore sent with bit 2177 first.
- R9: The staged map becomes active on the first clock edge at which `cfg_load` is low after having been high. Before that edge, the outputs follow the previous active map.
- R10: Asserting `rst_n` low at any time, including in the middle of a load, restores the unprogrammed map and discards the partial load.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_load | input | 1 | Load enable: shift while high, commit after it falls |
| cfg_din | input | 1 | Serial map data, most significant bit first |
| in_ded | input | 12 | Dedicated logic inputs |
| pin_in | input | 10 | Values present on the bidirectional pins |
| pin_out | output | 10 | Drive values after the polarity stage |
| pin_oe | output | 10 | Driver enables from the drive terms |

## Verification
Two functions meet in the same cycle: the shifting of a new map, and the evaluation of inputs under the old map. The bench stops in the middle of every load and compares the outputs with a model of the previously committed map, which judges R9. It also asserts reset halfway through a load and then expects the unprogrammed behaviour. A second overlap is pin feedback: a driven pin's own output is fed back into a term of another output in the same combinational settle, and the two outputs are compared directly.

// File: rtl/pla_core_pkg.sv
package pla_core_pkg;

  // Each logic variable owns a true link and a complement link.
  localparam int unsigned POLES = 2;

  // Total map length: AND links, then OR links, then polarity bits.
  function automatic int unsigned map_bits(input int unsigned n_ded,
                                           input int unsigned n_pin,
                                           input int unsigned n_pt);
    return (n_pt + n_pin) * POLES * (n_ded + n_pin) + n_pt * n_pin + n_pin;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_load,
  input  logic         cfg_din,
  output logic         rst_sync_n,
  output logic         load_q,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] map_q
);

  logic [1:0]   rsync_q;
  logic [W-1:0] shift_d;
  logic         commit;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // Next-state logic
  always_comb begin
    shift_d = {shift_q[W-2:0], cfg_din};
    commit  = load_q & ~cfg_load;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) load_q <= 1'b0;
    else             load_q <= cfg_load;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   shift_q <= '0;
    else if (cfg_load) shift_q <= shift_d;
  end

  // The active map resets to all links intact.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) map_q <= '1;
    else if (commit) map_q <= shift_q;
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_VAR  = 4,
  parameter int unsigned N_TERM = 4
) (
  input  logic [N_VAR-1:0]          vars,
  input  logic [N_TERM*2*N_VAR-1:0] links,
  output logic [N_TERM-1:0]         terms
);

  localparam int unsigned TERM_W = 2 * N_VAR;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_VAR-1:0] lit_ok;
    for (genvar v = 0; v < N_VAR; v++) begin : g_var
      // An intact true link needs a 1; an intact complement link needs a 0.
      assign lit_ok[v] = (~links[t*TERM_W + 2*v]     |  vars[v]) &
                         (~links[t*TERM_W + 2*v + 1] | ~vars[v]);
    end
    assign terms[t] = &lit_ok;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_PT  = 4,
  parameter int unsigned N_OUT = 2
) (
  input  logic [N_PT-1:0]       pterms,
  input  logic [N_OUT*N_PT-1:0] or_links,
  input  logic [N_OUT-1:0]      pol,
  output logic [N_OUT-1:0]      outs
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic sum;
    assign sum     = |(pterms & or_links[k*N_PT +: N_PT]);
    assign outs[k] = pol[k] ? sum : ~sum;
  end

endmodule

// File: rtl/pla_array_core.sv
module pla_array_core
  import pla_core_pkg::*;
#(
  parameter int unsigned N_DED = 12,
  parameter int unsigned N_PIN = 10,
  parameter int unsigned N_PT  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_din,
  input  logic [N_DED-1:0] in_ded,
  input  logic [N_PIN-1:0] pin_in,
  output logic [N_PIN-1:0] pin_out,
  output logic [N_PIN-1:0] pin_oe
);

  localparam int unsigned N_VAR  = N_DED + N_PIN;
  localparam int unsigned N_TERM = N_PT + N_PIN;
  localparam int unsigned AND_W  = N_TERM * POLES * N_VAR;
  localparam int unsigned OR_W   = N_PT * N_PIN;
  localparam int unsigned POL_W  = N_PIN;
  localparam int unsigned OR_LO  = POL_W;
  localparam int unsigned AND_LO = POL_W + OR_W;
  localparam int unsigned CFG_W  = map_bits(N_DED, N_PIN, N_PT);

  logic              rst_sync_n;
  logic              load_q;
  logic [CFG_W-1:0]  shift_q;
  logic [CFG_W-1:0]  map_q;
  logic [N_VAR-1:0]  vars;
  logic [N_TERM-1:0] terms;

  pla_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_din    (cfg_din),
    .rst_sync_n (rst_sync_n),
    .load_q     (load_q),
    .shift_q    (shift_q),
    .map_q      (map_q)
  );

  assign vars = {pin_in, in_ded};

  pla_and_plane #(.N_VAR(N_VAR), .N_TERM(N_TERM)) u_and (
    .vars  (vars),
    .links (map_q[AND_LO +: AND_W]),
    .terms (terms)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_PIN)) u_or (
    .pterms   (terms[N_PT-1:0]),
    .or_links (map_q[OR_LO +: OR_W]),
    .pol      (map_q[POL_W-1:0]),
    .outs     (pin_out)
  );

  assign pin_oe = terms[N_TERM-1:N_PT];

endmodule

// File: rtl/pla_array_core_chk.sv
module pla_array_core_chk #(
  parameter int unsigned CFG_W = 16,
  parameter int unsigned N_PIN = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cfg_load,
  input logic             cfg_din,
  input logic             load_q,
  input logic [CFG_W-1:0] shift_q,
  input logic [CFG_W-1:0] map_q,
  input logic [N_PIN-1:0] pin_out,
  input logic [N_PIN-1:0] pin_oe
);

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_load |=> (shift_q[0] == $past(cfg_din))); // R8

  AST_MAP_HELD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_load |=> $stable(map_q)); // R9

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_q && !cfg_load) |=> (map_q == $past(shift_q))); // R9

  AST_UNPROG_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&map_q) |-> (pin_out == '0 && pin_oe == '0)); // R7

  AST_OE_KNOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$isunknown(pin_oe)); // R5

endmodule

bind pla_array_core pla_array_core_chk #(.CFG_W(CFG_W), .N_PIN(N_PIN)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_load   (cfg_load),
  .cfg_din    (cfg_din),
  .load_q     (load_q),
  .shift_q    (shift_q),
  .map_q      (map_q),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/pla_array_core_bench.sv
module pla_array_core_bench;
  localparam int NDED = 12;
  localparam int NPIN = 10;
  localparam int NPT  = 32;
  localparam int NV   = NDED + NPIN;
  localparam int NT   = NPT + NPIN;
  localparam int NL   = 2 * NV;
  localparam int W    = pla_core_pkg::map_bits(NDED, NPIN, NPT);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_load = 1'b0;
  logic            cfg_din = 1'b0;
  logic [NDED-1:0] in_ded = '0;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out;
  logic [NPIN-1:0] pin_oe;

  int checks = 0;
  int errors = 0;

  // Expected model of the active map (cur) and of the map being staged (nxt)
  logic [NL-1:0]   cur_and [NT];
  logic [NPT-1:0]  cur_or  [NPIN];
  logic [NPIN-1:0] cur_pol;
  logic [NL-1:0]   nxt_and [NT];
  logic [NPT-1:0]  nxt_or  [NPIN];
  logic [NPIN-1:0] nxt_pol;

  always #5 clk = ~clk;

  pla_array_core u_pla_array_core (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
    .in_ded(in_ded), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input bit ok, input string req, input logic [NPIN-1:0] act,
                       input logic [NPIN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [NDED-1:0] d, input logic [NPIN-1:0] p,
                                output logic [NPIN-1:0] o, output logic [NPIN-1:0] oe);
    logic [NV-1:0] x;
    logic [NT-1:0] tm;
    x = {p, d};
    for (int t = 0; t < NT; t++) begin
      tm[t] = 1'b1;
      for (int v = 0; v < NV; v++) begin
        if (cur_and[t][2*v] && !x[v])   tm[t] = 1'b0;
        if (cur_and[t][2*v+1] && x[v])  tm[t] = 1'b0;
      end
    end
    for (int k = 0; k < NPIN; k++) begin
      logic s;
      s = |(tm[NPT-1:0] & cur_or[k]);
      o[k] = cur_pol[k] ? s : ~s;
    end
    oe = tm[NT-1:NPT];
  endfunction

  // Drive inputs, return driven pins on pin_in, compare with the model.
  task automatic apply(input logic [NDED-1:0] d, input logic [NPIN-1:0] ext, input string req);
    logic [NPIN-1:0] eo, eoe;
    in_ded = d;
    pin_in = ext;
    #1;
    pin_in = (pin_oe & pin_out) | (~pin_oe & ext);
    #1;
    model(d, pin_in, eo, eoe);
    check(pin_out === eo, req, pin_out, eo);
    check(pin_oe === eoe, req, pin_oe, eoe);
  endtask

  task automatic nxt_unprog();
    for (int t = 0; t < NT; t++) nxt_and[t] = '1;
    for (int k = 0; k < NPIN; k++) nxt_or[k] = '1;
    nxt_pol = '1;
  endtask

  task automatic cur_unprog();
    for (int t = 0; t < NT; t++) cur_and[t] = '1;
    for (int k = 0; k < NPIN; k++) cur_or[k] = '1;
    cur_pol = '1;
  endtask

  function automatic logic [W-1:0] pack_nxt();
    logic [W-1:0] v;
    for (int k = 0; k < NPIN; k++) v[k] = nxt_pol[k];
    for (int k = 0; k < NPIN; k++)
      for (int p = 0; p < NPT; p++) v[NPIN + k*NPT + p] = nxt_or[k][p];
    for (int t = 0; t < NT; t++)
      for (int l = 0; l < NL; l++) v[NPIN + NPIN*NPT + t*NL + l] = nxt_and[t][l];
    return v;
  endfunction

  // Shift the staged map in MSB first; mid-way, outputs must follow the old map.
  task automatic load_nxt();
    logic [W-1:0] v;
    v = pack_nxt();
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_din  = v[i];
      if (i == W / 2) apply(NDED'($urandom), NPIN'($urandom), "R9 old map held during shift");
    end
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
    cur_and = nxt_and;
    cur_or  = nxt_or;
    cur_pol = nxt_pol;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_unprog();
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 6; i++) begin
      in_ded = NDED'($urandom);
      pin_in = NPIN'($urandom);
      #1;
      check(pin_out === '0, "R7 unprogrammed out", pin_out, '0);
      check(pin_oe === '0, "R7 unprogrammed oe", pin_oe, '0);
    end
  endtask

  // 3-to-8 decoder on in_ded[2:0]; outputs 4..7 inverted; D0..D7 always on.
  task automatic t_decoder();
    nxt_unprog();
    for (int k = 0; k < 8; k++) begin
      nxt_and[k] = '0;
      for (int b = 0; b < 3; b++) nxt_and[k][2*b + ((k >> b) & 1 ? 0 : 1)] = 1'b1;
      nxt_or[k] = '0;
      nxt_or[k][k] = 1'b1;
      nxt_and[NPT + k] = '0;
      nxt_pol[k] = (k < 4);
    end
    nxt_or[8] = '0;
    nxt_or[9] = '0;
    load_nxt();
    for (int s = 0; s < 8; s++) begin
      logic [NPIN-1:0] exp;
      for (int k = 0; k < NPIN; k++) exp[k] = (k < 4) ? (s == k) : (k < 8) ? (s != k) : 1'b0;
      in_ded = NDED'({$urandom} << 3) | NDED'(s);
      pin_in = NPIN'($urandom);
      #1;
      check(pin_out === exp, "R1 R4 R8 decoder", pin_out, exp);
      check(pin_oe === 10'h0FF, "R5 decoder enables", pin_oe, 10'h0FF);
      apply(in_ded, pin_in, "R1 decoder model");
    end
  endtask

  // Output 3 gathers all 32 terms; output 5 uses only an inhibited term.
  task automatic t_wide_or();
    nxt_unprog();
    for (int p = 0; p < NPT; p++) begin
      nxt_and[p] = '0;
      for (int b = 0; b < 5; b++) nxt_and[p][2*b + ((p >> b) & 1 ? 0 : 1)] = 1'b1;
      nxt_and[p][10] = 1'b1;
    end
    nxt_and[5][14] = 1'b1;
    nxt_and[5][15] = 1'b1;
    for (int k = 0; k < NPIN; k++) nxt_or[k] = '0;
    nxt_or[3] = '1;
    nxt_or[4][0] = 1'b1;
    nxt_pol[4] = 1'b0;
    nxt_or[5][5] = 1'b1;
    for (int n = 3; n < 6; n++) nxt_and[NPT + n] = '0;
    load_nxt();
    for (int i = 0; i < 40; i++) begin
      logic [NDED-1:0] d;
      logic exp3;
      d = NDED'($urandom);
      if (i < 2) d[4:0] = 5'd5;
      exp3 = d[5] && (d[4:0] != 5'd5);
      in_ded = d;
      #1;
      check(pin_out[3] === exp3, "R3 32-wide OR", {9'b0, pin_out[3]}, {9'b0, exp3});
      check(pin_out[5] === 1'b0, "R2 inhibited term", {9'b0, pin_out[5]}, 10'h0);
      apply(d, NPIN'($urandom), "R3 R4 wide OR model");
    end
  endtask

  // Terms read pin values: undriven pins 5,6 and the driven pin 0.
  task automatic t_feedback();
    nxt_unprog();
    for (int k = 0; k < NPIN; k++) nxt_or[k] = '0;
    for (int n = 0; n < 5; n++) nxt_and[NPT + n] = '0;
    nxt_and[0] = '0; nxt_and[0][2*17] = 1'b1; nxt_and[0][0] = 1'b1;
    nxt_and[1] = '0; nxt_and[1][2*18+1] = 1'b1;
    nxt_and[2] = '0; nxt_and[2][2*12] = 1'b1;
    nxt_or[0][0] = 1'b1;
    nxt_or[1][1] = 1'b1;
    nxt_or[2][2] = 1'b1;
    load_nxt();
    for (int i = 0; i < 16; i++) begin
      logic [NPIN-1:0] ext;
      logic e0;
      ext = NPIN'($urandom);
      apply(NDED'($urandom), ext, "R6 feedback model");
      e0 = ext[5] & in_ded[0];
      check(pin_out[0] === e0, "R6 undriven pin term", pin_out, {9'b0, e0});
      check(pin_out[2] === pin_out[0], "R6 driven pin fed back", {9'b0, pin_out[2]}, {9'b0, pin_out[0]});
      check(pin_oe === 10'h01F, "R5 feedback enables", pin_oe, 10'h01F);
    end
  endtask

  task automatic t_random_map();
    nxt_unprog();
    for (int t = 0; t < NT; t++) begin
      nxt_and[t] = '0;
      for (int v = 0; v < NDED; v++) begin
        int r;
        r = int'($urandom % 8);
        if (r == 0) nxt_and[t][2*v] = 1'b1;
        if (r == 1) nxt_and[t][2*v+1] = 1'b1;
      end
    end
    for (int k = 0; k < NPIN; k++) nxt_or[k] = NPT'($urandom & $urandom);
    nxt_pol = NPIN'($urandom);
    load_nxt();
    for (int i = 0; i < 24; i++) apply(NDED'($urandom), NPIN'($urandom), "R1 R3 R4 R5 random map");
  endtask

  task automatic t_reset_midload();
    logic [W-1:0] v;
    nxt_unprog();
    for (int t = 0; t < NT; t++) nxt_and[t] = '0;
    v = pack_nxt();
    for (int i = W - 1; i >= W / 2; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_din  = v[i];
    end
    do_reset();
    for (int i = 0; i < 6; i++) begin
      in_ded = NDED'($urandom);
      pin_in = NPIN'($urandom);
      #1;
      check(pin_out === '0, "R10 reset mid-load out", pin_out, '0);
      check(pin_oe === '0, "R10 reset mid-load oe", pin_oe, '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all): actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_unprog();
    nxt_unprog();
    do_reset();
    t_reset_state();
    t_decoder();
    t_wide_or();
    t_feedback();
    t_random_map();
    t_random_map();
    t_reset_midload();
    t_decoder();
    do_reset();
    t_reset_state();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule